// File: doc/BRIEF.md
# Dual Look-Up Table Logic Cell

This block is one programmable logic cell. It holds two 64-cell look-up tables, a 2:1 merge multiplexer and one flip-flop. Each table cell stores one minterm of a function. A stored 1 puts that input combination into the sum-of-products output, and a stored 0 leaves it out. The tables are filled one bit at a time through a small write port. Reset clears every cell to zero.

A two-bit mode input selects how the parts are wired:
- **Split mode:** the cell produces two independent functions of up to six variables each. The two functions share four of the eight function inputs.
- **Merged mode:** both tables read the same six low inputs, and input 6 picks which table's answer is passed on. Together they form any function of seven variables.
- **Chain mode:** the flip-flop takes its data from a neighbour cell rather than from a table. Cells wired output-to-input then form a shift register.

Top module: `dual_lut_cell`

## Requirements
- R1: After reset (rst_n low), every table cell and the flip-flop hold 0. Until a write is made, y0, y1 and chain_out stay 0 for any fin, mode or ce value.
- R2: When cfg_we is 1 at a rising clock edge, cfg_bit is stored in one cell. cfg_addr[6] selects the table (0 = table A, 1 = table B) and cfg_addr[5:0] is the cell index. The new value shows at the outputs right after that edge.
- R3: In split mode (mode = 2'b00), y0 equals table A at index fin[5:0].
- R4: In split mode, y1 equals table B at index fin[7:2]. Inputs fin[5:2] are shared by both functions.
- R5: The reserved code mode = 2'b11 behaves exactly as split mode on y0 and y1.
- R6: In merged mode (mode = 2'b01), y0 equals table B at fin[5:0] when fin[6] is 1, and table A at fin[5:0] when fin[6] is 0. fin[7] has no effect on y0.
- R7: In every mode except 2'b10, a rising edge with ce = 1 loads the flip-flop with the y0 value present before the edge. chain_out always shows the flip-flop.
- R8: In merged mode, y1 shows the flip-flop, so y1 is the registered 7-variable function.
- R9: In chain mode (mode = 2'b10), a rising edge with ce = 1 loads the flip-flop from chain_in. y1 shows the flip-flop, and y0 equals table A at fin[5:0].
- R10: A rising edge with ce = 0 leaves the flip-flop unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fin | input | 8 | Function inputs |
| mode | input | 2 | 00 split, 01 merged, 10 chain, 11 reserved (split) |
| ce | input | 1 | Flip-flop clock enable |
| chain_in | input | 1 | Data from the preceding cell in a chain |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 7 | Table select (bit 6) and cell index (bits 5:0) |
| cfg_bit | input | 1 | Value written into the addressed cell |
| y0 | output | 1 | Primary function output |
| y1 | output | 1 | Second function (split) or flip-flop (merged, chain) |
| chain_out | output | 1 | Flip-flop output towards the next cell |

## Verification
The checker properties assume that mode, ce, chain_in and the write-port signals are known, two-valued levels at every rising edge. They also assume a single write per edge. The write-visibility property further assumes that mode and fin are already settled when the cycle after the write starts.

The bench changes every input only on the falling clock edge and never leaves an input undriven. Random cycles mix table writes with evaluation in all four mode codes, so these assumptions hold throughout the run.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,
        MODE_MERGE  = 2'b01,
        MODE_CHAIN  = 2'b10,
        MODE_RSVD   = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic ff;
    } cell_state_t;

endpackage

// File: rtl/dlc_lut_bank.sv
module dlc_lut_bank #(
    parameter int LUT_K  = 6,
    parameter int N_TBL  = 2,
    localparam int DEPTH = 1 << LUT_K,
    localparam int SEL_W = (N_TBL > 1) ? $clog2(N_TBL) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SEL_W-1:0]            tbl_sel,
    input  logic [LUT_K-1:0]            cell_idx,
    input  logic                        wbit,
    output logic [N_TBL-1:0][DEPTH-1:0] tables
);

    logic [N_TBL-1:0][DEPTH-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int t = 0; t < N_TBL; t++) begin
            if (we && (int'(tbl_sel) == t)) begin
                tbl_d[t][cell_idx] = wbit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign tables = tbl_q;

endmodule

// File: rtl/dlc_lut_read.sv
module dlc_lut_read #(
    parameter int LUT_K  = 6,
    localparam int DEPTH = 1 << LUT_K
) (
    input  logic [DEPTH-1:0] cells,
    input  logic [LUT_K-1:0] idx,
    output logic             val
);

    always_comb begin
        val = cells[idx];
    end

endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell
    import dlc_pkg::*;
#(
    parameter int LUT_K  = 6,
    parameter int N_FIN  = 8,
    localparam int DEPTH = 1 << LUT_K,
    localparam int CFG_W = LUT_K + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_FIN-1:0] fin,
    input  logic [1:0]       mode,
    input  logic             ce,
    input  logic             chain_in,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_addr,
    input  logic             cfg_bit,
    output logic             y0,
    output logic             y1,
    output logic             chain_out
);

    localparam int N_TBL = 2;

    cell_mode_e                  mode_e;
    logic [N_TBL-1:0][DEPTH-1:0] tables;
    logic [N_TBL-1:0][LUT_K-1:0] rd_idx;
    logic [N_TBL-1:0]            rd_val;
    logic                        merged;
    logic                        merge_out;
    cell_state_t                 st_d, st_q;

    assign mode_e = cell_mode_e'(mode);
    assign merged = (mode_e == MODE_MERGE);

    dlc_lut_bank #(
        .LUT_K (LUT_K),
        .N_TBL (N_TBL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .tbl_sel  (cfg_addr[LUT_K]),
        .cell_idx (cfg_addr[LUT_K-1:0]),
        .wbit     (cfg_bit),
        .tables   (tables)
    );

    // Table A always reads the low inputs; table B reads the high inputs
    // in split mode and the same low inputs when the tables are merged.
    always_comb begin
        rd_idx[0] = fin[LUT_K-1:0];
        rd_idx[1] = merged ? fin[LUT_K-1:0] : fin[N_FIN-1 -: LUT_K];
    end

    for (genvar t = 0; t < N_TBL; t++) begin : g_read
        dlc_lut_read #(
            .LUT_K (LUT_K)
        ) u_read (
            .cells (tables[t]),
            .idx   (rd_idx[t]),
            .val   (rd_val[t])
        );
    end

    // Merge multiplexer: complemented select gates table A.
    assign merge_out = (rd_val[1] & fin[LUT_K]) | (rd_val[0] & ~fin[LUT_K]);

    always_comb begin
        y0 = merged ? merge_out : rd_val[0];
        unique case (mode_e)
            MODE_MERGE,
            MODE_CHAIN: y1 = st_q.ff;
            default:    y1 = rd_val[1];
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.ff = (mode_e == MODE_CHAIN) ? chain_in : y0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_out = st_q.ff;

endmodule

// File: rtl/dual_lut_cell_chk.sv
module dual_lut_cell_chk #(
    parameter int LUT_K  = 6,
    parameter int N_FIN  = 8,
    localparam int CFG_W = LUT_K + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_FIN-1:0] fin,
    input logic [1:0]       mode,
    input logic             ce,
    input logic             chain_in,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_addr,
    input logic             cfg_bit,
    input logic             y0,
    input logic             y1,
    input logic             chain_out
);

    AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && mode == 2'b10) |=> (chain_out == $past(chain_in)));   // R9

    AST_FF_FROM_Y0: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && mode != 2'b10) |=> (chain_out == $past(y0)));          // R7

    AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(chain_out));                                   // R10

    AST_Y1_IS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 || mode == 2'b10) |-> (y1 == chain_out));      // R8

    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr[LUT_K]) |=>
        ((mode == 2'b00 && fin[LUT_K-1:0] == $past(cfg_addr[LUT_K-1:0]))
            ? (y0 == $past(cfg_bit)) : 1'b1));                        // R2

endmodule

bind dual_lut_cell dual_lut_cell_chk #(
    .LUT_K (LUT_K),
    .N_FIN (N_FIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .mode      (mode),
    .ce        (ce),
    .chain_in  (chain_in),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_bit   (cfg_bit),
    .y0        (y0),
    .y1        (y1),
    .chain_out (chain_out)
);

// File: tb/dual_lut_cell_test.sv
module dual_lut_cell_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fin = '0;
    logic [1:0] mode = '0;
    logic       ce = 1'b0;
    logic       chain_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic       cfg_bit = 1'b0;
    logic       y0, y1, chain_out;

    int total = 0;
    int bad = 0;

    logic [63:0] ref_a = '0;
    logic [63:0] ref_b = '0;
    logic        ref_ff = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_lut_cell uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (fin),
        .mode      (mode),
        .ce        (ce),
        .chain_in  (chain_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_bit   (cfg_bit),
        .y0        (y0),
        .y1        (y1),
        .chain_out (chain_out)
    );

    function automatic logic exp_y0(input logic [1:0] m, input logic [7:0] f);
        if (m == 2'b01) return f[6] ? ref_b[f[5:0]] : ref_a[f[5:0]];
        return ref_a[f[5:0]];
    endfunction

    function automatic logic exp_y1(input logic [1:0] m, input logic [7:0] f);
        if (m == 2'b01 || m == 2'b10) return ref_ff;
        return ref_b[f[7:2]];
    endfunction

    function automatic string y0_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R6";
            2'b10:   return "R9";
            default: return "R5";
        endcase
    endfunction

    function automatic string y1_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R4";
            2'b01:   return "R8";
            2'b10:   return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b (mode=%b fin=%h)",
                     tag, what, act, exp, mode, fin);
        end
    endtask

    // Inputs are set just after a falling edge; outputs are compared
    // 1 time unit later; the model then advances for the next rising edge.
    task automatic step(input logic [7:0] f, input logic [1:0] m,
                        input logic c, input logic ci, input logic we,
                        input logic [6:0] a, input logic b, input string ff_tag);
        fin = f; mode = m; ce = c; chain_in = ci;
        cfg_we = we; cfg_addr = a; cfg_bit = b;
        #1;
        check(y0_tag(m), "y0", y0, exp_y0(m, f));
        check(y1_tag(m), "y1", y1, exp_y1(m, f));
        check(ff_tag, "chain_out", chain_out, ref_ff);
        if (c) ref_ff = (m == 2'b10) ? ci : exp_y0(m, f);
        if (we) begin
            if (a[6]) ref_b[a[5:0]] = b;
            else      ref_a[a[5:0]] = b;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state, with random inputs and no writes
        for (int i = 0; i < 4; i++) begin
            fin = 8'($urandom); mode = 2'(i); ce = 1'b1; chain_in = 1'b1;
            #1;
            check("R1", "y0", y0, 1'b0);
            check("R1", "y1", y1, 1'b0);
            check("R1", "chain_out", chain_out, 1'b0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "chain_out", chain_out, 1'b0);

        // R2: fill both tables with known patterns through the write port
        for (int i = 0; i < 128; i++) begin
            logic [6:0] a;
            a = 7'(i);
            step(8'($urandom), 2'b00, 1'b0, 1'b0, 1'b1, a,
                 a[6] ? a[0] ^ a[3] : ^a[5:0], "R10");
        end

        // R6: exhaustive merged-mode sweep, fin[7] toggled
        for (int i = 0; i < 256; i++) begin
            step(8'(i), 2'b01, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R10");
        end

        // R3/R4/R5: exhaustive split and reserved sweeps
        for (int i = 0; i < 256; i++) begin
            step(8'(i), 2'b00, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R10");
            step(8'(i), 2'b11, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R10");
        end

        // R9: directed shift of a pattern through the chain flip-flop
        for (int i = 0; i < 16; i++) begin
            step(8'($urandom), 2'b10, 1'b1, 1'(16'hA5C3 >> i), 1'b0, '0, 1'b0, "R9");
        end

        // R2: write then read back at once in split mode
        step(8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 7'h15, ~ref_a[6'h15], "R2");
        step(8'h15, 2'b00, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R2");
        step(8'hD4, 2'b00, 1'b0, 1'b0, 1'b1, 7'h75, ~ref_b[6'h35], "R2");
        step(8'hD4, 2'b00, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R2");

        // R7/R8/R10: random mix of writes, modes and enables
        for (int i = 0; i < 3000; i++) begin
            logic       c;
            logic [1:0] m;
            c = 1'($urandom);
            m = 2'($urandom);
            step(8'($urandom), m, c, 1'($urandom),
                 ($urandom % 4) == 0, 7'($urandom), 1'($urandom),
                 c ? ((m == 2'b10) ? "R9" : "R7") : "R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule